// File: doc/BRIEF.md
# IOMMU Context Register Bank

This block holds the per-context control and fault-reporting registers of an I/O memory management unit with up to sixteen translation contexts. Software reaches it over a plain 32-bit register bus: a write strobe with address and data, and a read data output that follows the address within the same cycle. Each context stores a translation enable, an interrupt enable, a translation-control word, a bus-control word, a two-word table base and a memory-attribute word. It also runs a self-clearing TLB-flush handshake that models invalidation time as a fixed number of clock cycles.

An abstract translation engine reports faults through an inject port that names a context, a fault kind and a faulting address. The context holds the first fault it sees, as a status flag and a captured address, until software clears the status by writing zero to it. The interrupt output is raised while any context has both a pending fault and its interrupt enable set.

Top module: `ctxreg_bank`

## Requirements
- R1: Context n below 8 occupies byte addresses n*0x40 to n*0x40+0x3F; context n from 8 to 15 occupies 0x800+(n-8)*0x40 onward. Inside a context only offsets 0x00, 0x08, 0x0C, 0x10, 0x14, 0x20, 0x28, 0x30 and 0x34 exist. Any other address reads 0, and a write to it changes no register.
- R2: Offsets 0x08 (translation control), 0x0C (bus control), 0x10 (table base low), 0x14 (table base high) and 0x28 (memory attributes) store all 32 written bits and read them back unchanged.
- R3: At offset 0x00, bit 0 is translation enable and bit 2 is interrupt enable, both stored on every write; bits 31:3 read 0. Writing bit 1 as 1 makes bit 1 read 1 for exactly FLUSH_CYCLES cycles after the write edge, then 0. A write with bit 1 as 0 does not shorten a pending flush, and a new flush write restarts the count.
- R4: A fault inject with kind code 0 sets status bit 0 (translation fault), code 1 sets bit 1 (permission fault), code 2 sets bit 2 (walk abort) and code 3 sets bit 4 (multiple hit), all at offset 0x20. The fault address is loaded at the same edge: bits 31:0 read at 0x30, and bits FADDR_W-1:32 read zero-extended at 0x34.
- R5: While a context's status is non-zero, further faults for it change neither status nor captured address.
- R6: Writing 0 to the status offset clears every status flag and the captured address to 0. A non-zero write to the status offset changes nothing.
- R7: A fault that arrives in the same cycle as a clearing write to its context is captured.
- R8: The interrupt output is 1 exactly when some context has interrupt enable set and a non-zero status, following register state with no added delay.
- R9: After synchronous reset every register reads 0, no flush is pending and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| flt_valid | input | 1 | Fault inject strobe |
| flt_ctx | input | 4 | Context receiving the fault |
| flt_kind | input | 2 | Fault kind code (R4) |
| flt_addr | input | FADDR_W | Faulting address |
| irq | output | 1 | Aggregated fault interrupt |

## Verification
The bench aims at the gap between 0x200 and 0x7FF and at the seam between contexts 7 and 8, where a decoder that ignored the split window would alias context 8 onto a wrong slot or store writes from holes. It counts flush-busy cycles exactly and writes while busy, which would expose an off-by-one counter or a flush cancelled by a zero write. It sends a second fault to a context holding one, nonzero and zero writes to status, and a fault coincident with a clear; a write-one-to-clear status, an overwritten first fault, a fault address that survives the clear or a lost coincident fault each shows up as a read mismatch. Interrupt checks cover faults with the enable off, then on, so an interrupt that ignores the enable would be caught.

// File: rtl/ctxreg_pkg.sv
package ctxreg_pkg;

    localparam int ADDR_W   = 12;
    localparam int MAX_CTX  = 16;
    localparam int ID_W     = 4;
    localparam int FLAG_W   = 5;

    // Status flag positions read by software
    localparam int FL_XLATE = 0;
    localparam int FL_PERM  = 1;
    localparam int FL_WALK  = 2;
    localparam int FL_MHIT  = 4;

    typedef enum logic [3:0] {
        RS_NONE, RS_CTRL, RS_TCTL, RS_BCTL, RS_TBLO,
        RS_TBHI, RS_STAT, RS_ATTR, RS_FALO, RS_FAHI
    } reg_sel_e;

    typedef enum logic [1:0] {
        FK_XLATE = 2'd0,
        FK_PERM  = 2'd1,
        FK_WALK  = 2'd2,
        FK_MHIT  = 2'd3
    } fault_kind_e;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
        reg_sel_e        sel;
    } dec_t;

    typedef struct packed {
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [31:0] tctl;
        logic [31:0] bctl;
        logic [31:0] tb_lo;
        logic [31:0] tb_hi;
        logic [31:0] attr;
    } cfg_t;

    function automatic reg_sel_e offset_to_sel(input logic [5:0] off);
        case (off)
            6'h00:   return RS_CTRL;
            6'h08:   return RS_TCTL;
            6'h0C:   return RS_BCTL;
            6'h10:   return RS_TBLO;
            6'h14:   return RS_TBHI;
            6'h20:   return RS_STAT;
            6'h28:   return RS_ATTR;
            6'h30:   return RS_FALO;
            6'h34:   return RS_FAHI;
            default: return RS_NONE;
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] kind_to_flag(input fault_kind_e k);
        logic [FLAG_W-1:0] f;
        f = '0;
        case (k)
            FK_XLATE: f[FL_XLATE] = 1'b1;
            FK_PERM:  f[FL_PERM]  = 1'b1;
            FK_WALK:  f[FL_WALK]  = 1'b1;
            default:  f[FL_MHIT]  = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ctxreg_decode.sv
module ctxreg_decode
    import ctxreg_pkg::*;
#(
    parameter int NUM_CTX = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic lo_win;
    logic hi_win;
    logic [ID_W-1:0] id;
    reg_sel_e sel;

    // Contexts 0..7 sit in 0x000-0x1FF, contexts 8..15 in 0x800-0x9FF
    always_comb begin
        lo_win = (addr[ADDR_W-1:9] == 3'b000);
        hi_win = (addr[ADDR_W-1:9] == 3'b100);
        id     = {hi_win, addr[8:6]};
        sel    = offset_to_sel(addr[5:0]);
        dec.id  = id;
        dec.sel = sel;
        dec.hit = (lo_win || hi_win) && ({1'b0, id} < 5'(NUM_CTX)) && (sel != RS_NONE);
    end
endmodule

// File: rtl/ctxreg_flush.sv
module ctxreg_flush #(
    parameter int FLUSH_CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(FLUSH_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/ctxreg_slot.sv
module ctxreg_slot
    import ctxreg_pkg::*;
#(
    parameter int FLUSH_CYCLES = 6,
    parameter int FADDR_W      = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  reg_sel_e           sel,
    input  logic [31:0]        wdata,
    input  logic               flt_fire,
    input  fault_kind_e        flt_kind,
    input  logic [FADDR_W-1:0] flt_addr,
    output logic [31:0]        rdata,
    output logic [FLAG_W-1:0]  stat,
    output logic [FADDR_W-1:0] faddr,
    output logic               busy,
    output logic               irq
);
    ctrl_t ctrl;
    cfg_t  cfg;

    logic               flush_start;
    logic               clr;
    logic [FLAG_W-1:0]  stat_base, stat_nxt;
    logic [FADDR_W-1:0] fa_base, fa_nxt;
    logic [63:0]        fa_wide;

    assign flush_start = wr && (sel == RS_CTRL) && wdata[1];
    assign clr         = wr && (sel == RS_STAT) && (wdata == '0);

    ctxreg_flush #(.FLUSH_CYCLES(FLUSH_CYCLES)) flush_i (
        .clk   (clk),
        .rst   (rst),
        .start (flush_start),
        .busy  (busy)
    );

    // Clear first, then a fault may land on the cleared context
    always_comb begin
        stat_base = clr ? '0 : stat;
        fa_base   = clr ? '0 : faddr;
        stat_nxt  = stat_base;
        fa_nxt    = fa_base;
        if (flt_fire && (stat_base == '0)) begin
            stat_nxt = kind_to_flag(flt_kind);
            fa_nxt   = flt_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            cfg   <= '0;
            stat  <= '0;
            faddr <= '0;
        end else begin
            stat  <= stat_nxt;
            faddr <= fa_nxt;
            if (wr) begin
                case (sel)
                    RS_CTRL: begin
                        ctrl.en <= wdata[0];
                        ctrl.ie <= wdata[2];
                    end
                    RS_TCTL: cfg.tctl  <= wdata;
                    RS_BCTL: cfg.bctl  <= wdata;
                    RS_TBLO: cfg.tb_lo <= wdata;
                    RS_TBHI: cfg.tb_hi <= wdata;
                    RS_ATTR: cfg.attr  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign fa_wide = 64'(faddr);

    always_comb begin
        case (sel)
            RS_CTRL: rdata = {29'b0, ctrl.ie, busy, ctrl.en};
            RS_TCTL: rdata = cfg.tctl;
            RS_BCTL: rdata = cfg.bctl;
            RS_TBLO: rdata = cfg.tb_lo;
            RS_TBHI: rdata = cfg.tb_hi;
            RS_STAT: rdata = 32'(stat);
            RS_ATTR: rdata = cfg.attr;
            RS_FALO: rdata = fa_wide[31:0];
            RS_FAHI: rdata = fa_wide[63:32];
            default: rdata = '0;
        endcase
    end

    assign irq = ctrl.ie && (stat != '0);
endmodule

// File: rtl/ctxreg_bank.sv
module ctxreg_bank
    import ctxreg_pkg::*;
#(
    parameter int NUM_CTX      = 16,
    parameter int FLUSH_CYCLES = 6,
    parameter int FADDR_W      = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               flt_valid,
    input  logic [3:0]         flt_ctx,
    input  logic [1:0]         flt_kind,
    input  logic [FADDR_W-1:0] flt_addr,
    output logic               irq
);
    dec_t dec;

    logic [31:0]        slot_rd   [NUM_CTX];
    logic [FLAG_W-1:0]  slot_stat [NUM_CTX];
    logic [FADDR_W-1:0] slot_fa   [NUM_CTX];
    logic [NUM_CTX-1:0] slot_busy;
    logic [NUM_CTX-1:0] slot_irq;

    ctxreg_decode #(.NUM_CTX(NUM_CTX)) dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        logic slot_wr;
        logic slot_fire;
        assign slot_wr   = bus_wr && dec.hit && (dec.id == ID_W'(g));
        assign slot_fire = flt_valid && (flt_ctx == ID_W'(g));

        ctxreg_slot #(
            .FLUSH_CYCLES (FLUSH_CYCLES),
            .FADDR_W      (FADDR_W)
        ) slot_i (
            .clk      (clk),
            .rst      (rst),
            .wr       (slot_wr),
            .sel      (dec.sel),
            .wdata    (bus_wdata),
            .flt_fire (slot_fire),
            .flt_kind (fault_kind_e'(flt_kind)),
            .flt_addr (flt_addr),
            .rdata    (slot_rd[g]),
            .stat     (slot_stat[g]),
            .faddr    (slot_fa[g]),
            .busy     (slot_busy[g]),
            .irq      (slot_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CTX; i++)
            if (dec.hit && (dec.id == ID_W'(i)))
                bus_rdata = slot_rd[i];
    end

    assign irq = |slot_irq;
endmodule

// File: rtl/ctxreg_bank_chk.sv
module ctxreg_bank_chk
    import ctxreg_pkg::*;
#(
    parameter int NUM_CTX      = 16,
    parameter int FLUSH_CYCLES = 6,
    parameter int FADDR_W      = 40
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               irq,
    input logic [FLAG_W-1:0]  slot_stat [NUM_CTX],
    input logic [FADDR_W-1:0] slot_fa   [NUM_CTX],
    input logic [NUM_CTX-1:0] slot_busy
);
    logic any_stat;

    always_comb begin
        any_stat = 1'b0;
        for (int i = 0; i < NUM_CTX; i++)
            if (slot_stat[i] != '0) any_stat = 1'b1;
    end

    // R8: interrupt only with a fault pending somewhere
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> any_stat);

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        localparam int BASE = (i < 8) ? i * 64 : 2048 + (i - 8) * 64;

        logic flush_wr;
        logic clr_wr;
        int   run;

        assign flush_wr = bus_wr && (bus_addr == 12'(BASE)) && bus_wdata[1];
        assign clr_wr   = bus_wr && (bus_addr == 12'(BASE + 32)) && (bus_wdata == '0);

        always_ff @(posedge clk) begin
            if (rst || flush_wr)
                run <= 0;
            else if (slot_busy[i])
                run <= run + 1;
            else
                run <= 0;
        end

        // R3: a flush write makes the context busy at the next edge
        p_flush_starts_r3: assert property (@(posedge clk) disable iff (rst)
            flush_wr |=> slot_busy[i]);

        // R3: busy never outlasts the flush window
        p_flush_bounded_r3: assert property (@(posedge clk) disable iff (rst)
            slot_busy[i] |-> (run < FLUSH_CYCLES));

        // R4: one fault kind is recorded at a time
        p_single_flag_r4: assert property (@(posedge clk) disable iff (rst)
            $onehot0(slot_stat[i]));

        // R5: a held fault stays until a clearing write
        p_first_held_r5: assert property (@(posedge clk) disable iff (rst)
            ((slot_stat[i] != '0) && !clr_wr) |=> $stable(slot_stat[i]) && $stable(slot_fa[i]));

        // R6: no captured address without a status flag
        p_addr_cleared_r6: assert property (@(posedge clk) disable iff (rst)
            (slot_stat[i] == '0) |-> (slot_fa[i] == '0));
    end
endmodule

bind ctxreg_bank ctxreg_bank_chk #(
    .NUM_CTX      (NUM_CTX),
    .FLUSH_CYCLES (FLUSH_CYCLES),
    .FADDR_W      (FADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .slot_stat (slot_stat),
    .slot_fa   (slot_fa),
    .slot_busy (slot_busy)
);

// File: tb/ctxreg_bank_tb_top.sv
module ctxreg_bank_tb_top;
    localparam int NCTX  = 16;
    localparam int FLUSH = 6;
    localparam int FAW   = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic           bus_wr;
    logic [11:0]    bus_addr;
    logic [31:0]    bus_wdata;
    logic [31:0]    bus_rdata;
    logic           flt_valid;
    logic [3:0]     flt_ctx;
    logic [1:0]     flt_kind;
    logic [FAW-1:0] flt_addr;
    logic           irq;

    ctxreg_bank #(.NUM_CTX(NCTX), .FLUSH_CYCLES(FLUSH), .FADDR_W(FAW)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
        .flt_ctx(flt_ctx), .flt_kind(flt_kind), .flt_addr(flt_addr), .irq(irq)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R9";

    // Behavioural reference state
    bit        m_en   [NCTX];
    bit        m_ie   [NCTX];
    int        m_cnt  [NCTX];
    bit [31:0] m_tctl [NCTX];
    bit [31:0] m_bctl [NCTX];
    bit [31:0] m_tblo [NCTX];
    bit [31:0] m_tbhi [NCTX];
    bit [31:0] m_attr [NCTX];
    bit [4:0]  m_stat [NCTX];
    bit [63:0] m_fa   [NCTX];

    function automatic int ctx_of(input bit [11:0] a);
        int v = int'(a);
        if (v < 'h200) return v / 64;
        if (v >= 'h800 && v < 'hA00) return 8 + (v - 'h800) / 64;
        return -1;
    endfunction

    function automatic bit [11:0] ra(input int ctx, input int off);
        if (ctx < 8) return 12'(ctx * 64 + off);
        return 12'('h800 + (ctx - 8) * 64 + off);
    endfunction

    function automatic bit [31:0] m_read(input bit [11:0] a);
        int id = ctx_of(a);
        if (id < 0 || id >= NCTX) return 0;
        case (int'(a) % 64)
            0:  return {29'b0, m_ie[id], m_cnt[id] != 0, m_en[id]};
            8:  return m_tctl[id];
            12: return m_bctl[id];
            16: return m_tblo[id];
            20: return m_tbhi[id];
            32: return {27'b0, m_stat[id]};
            40: return m_attr[id];
            48: return m_fa[id][31:0];
            52: return m_fa[id][63:32];
            default: return 0;
        endcase
    endfunction

    function automatic string class_tag(input bit [11:0] a);
        int id = ctx_of(a);
        int off = int'(a) % 64;
        if (cur_tag != "") return cur_tag;
        if (id < 0 || !(off inside {0, 8, 12, 16, 20, 32, 40, 48, 52})) return "R1";
        if (off == 0) return "R3";
        if (off inside {32, 48, 52}) return "R5";
        return "R2";
    endfunction

    function automatic bit m_irq();
        for (int i = 0; i < NCTX; i++)
            if (m_ie[i] && m_stat[i] != 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit [4:0] flag_of(input int k);
        case (k)
            0: return 5'b00001;
            1: return 5'b00010;
            2: return 5'b00100;
            default: return 5'b10000;
        endcase
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NCTX; i++) begin
            m_en[i] = 0; m_ie[i] = 0; m_cnt[i] = 0;
            m_tctl[i] = 0; m_bctl[i] = 0; m_tblo[i] = 0; m_tbhi[i] = 0;
            m_attr[i] = 0; m_stat[i] = 0; m_fa[i] = 0;
        end
    endtask

    task automatic check(input string tag, input bit [31:0] got, input bit [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h (addr 0x%03h)", tag, got, exp, bus_addr);
        end
    endtask

    // One bus cycle: drive at negedge, compare, then advance the model at posedge
    task automatic step(input bit wr, input bit [11:0] a, input bit [31:0] d,
                        input bit fv, input int fc, input int fk, input bit [63:0] fa);
        int  id;
        int  clr;
        bit [4:0]  sb;
        bit [63:0] fb;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        flt_valid = fv; flt_ctx = 4'(fc); flt_kind = 2'(fk); flt_addr = FAW'(fa);
        #1;
        check(class_tag(a), bus_rdata, m_read(a));
        check("R8", {31'b0, irq}, {31'b0, m_irq()});
        @(posedge clk);
        for (int i = 0; i < NCTX; i++) if (m_cnt[i] > 0) m_cnt[i]--;
        id = ctx_of(a);
        clr = -1;
        if (wr && id >= 0 && id < NCTX) begin
            case (int'(a) % 64)
                0: begin
                    m_en[id] = d[0]; m_ie[id] = d[2];
                    if (d[1]) m_cnt[id] = FLUSH;
                end
                8:  m_tctl[id] = d;
                12: m_bctl[id] = d;
                16: m_tblo[id] = d;
                20: m_tbhi[id] = d;
                32: if (d == 0) clr = id;
                40: m_attr[id] = d;
                default: ;
            endcase
        end
        for (int i = 0; i < NCTX; i++) begin
            sb = (i == clr) ? 5'b0 : m_stat[i];
            fb = (i == clr) ? 64'b0 : m_fa[i];
            if (fv && fc == i && sb == 0) begin
                sb = flag_of(fk);
                fb = fa & ((64'd1 << FAW) - 1);
            end
            m_stat[i] = sb;
            m_fa[i] = fb;
        end
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        step(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd(input bit [11:0] a);
        step(0, a, 0, 0, 0, 0, 0);
    endtask

    task automatic flt(input int c, input int k, input bit [63:0] fa, input bit [11:0] a);
        step(0, a, 0, 1, c, k, fa);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        flt_valid = 0; flt_ctx = 0; flt_kind = 0; flt_addr = 0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R9: everything reads zero after reset
        cur_tag = "R9";
        foreach (m_en[c]) begin
            rd(ra(c, 'h00)); rd(ra(c, 'h20)); rd(ra(c, 'h10));
        end

        // R2: storage registers, across the window seam
        cur_tag = "R2";
        foreach (m_en[c]) begin
            wr(ra(c, 'h08), 32'hA500_0000 + 32'(c));
            wr(ra(c, 'h0C), 32'h0000_5A00 ^ 32'(c * 7));
            wr(ra(c, 'h10), 32'hDEAD_0000 | 32'(c));
            wr(ra(c, 'h14), 32'h0000_00F0 + 32'(c));
            wr(ra(c, 'h28), 32'hFFFF_FFFF - 32'(c));
        end
        foreach (m_en[c]) begin
            rd(ra(c, 'h08)); rd(ra(c, 'h0C)); rd(ra(c, 'h10));
            rd(ra(c, 'h14)); rd(ra(c, 'h28));
        end

        // R1: holes, unmapped offsets, writes there ignored
        cur_tag = "R1";
        wr(12'h204, 32'h1111_1111); wr(12'h7C8, 32'h2222_2222);
        wr(12'hA08, 32'h3333_3333); wr(12'h004, 32'h4444_4444);
        wr(12'h83C, 32'h5555_5555); wr(12'hC08, 32'h6666_6666);
        rd(12'h204); rd(12'h7C8); rd(12'hA08); rd(12'h004);
        rd(12'h83C); rd(12'h608); rd(12'h208); rd(12'hC08);
        rd(ra(0, 'h08)); rd(ra(8, 'h08)); rd(ra(7, 'h28)); rd(ra(15, 'h28));

        // R3: control bits and flush timing
        cur_tag = "R3";
        wr(ra(3, 0), 32'hFFFF_FFFF);
        repeat (FLUSH + 2) rd(ra(3, 0));
        wr(ra(9, 0), 32'h2);
        rd(ra(9, 0)); rd(ra(9, 0));
        wr(ra(9, 0), 32'h5);
        repeat (FLUSH + 1) rd(ra(9, 0));
        wr(ra(12, 0), 32'h2);
        repeat (3) rd(ra(12, 0));
        wr(ra(12, 0), 32'h2);
        repeat (FLUSH + 2) rd(ra(12, 0));

        // R4: each fault kind with address capture
        cur_tag = "R4";
        flt(1, 0, 64'h00AB_1234_5678, ra(1, 'h20));
        rd(ra(1, 'h20)); rd(ra(1, 'h30)); rd(ra(1, 'h34));
        flt(2, 1, 64'h0001_0000_0004, ra(2, 'h20));
        rd(ra(2, 'h20)); rd(ra(2, 'h34));
        flt(10, 2, 64'h00FF_FFFF_FFFF, ra(10, 'h20));
        rd(ra(10, 'h20)); rd(ra(10, 'h30)); rd(ra(10, 'h34));
        flt(15, 3, 64'hFFFF_FF80_0000_1000, ra(15, 'h20));
        rd(ra(15, 'h20)); rd(ra(15, 'h34));

        // R5: second fault ignored
        cur_tag = "R5";
        flt(1, 3, 64'h0011_2233_4455, ra(1, 'h20));
        rd(ra(1, 'h20)); rd(ra(1, 'h30)); rd(ra(1, 'h34));

        // R6: nonzero write kept, zero write clears
        cur_tag = "R6";
        wr(ra(1, 'h20), 32'h0000_0001);
        rd(ra(1, 'h20)); rd(ra(1, 'h30));
        wr(ra(1, 'h20), 32'h0);
        rd(ra(1, 'h20)); rd(ra(1, 'h30)); rd(ra(1, 'h34));
        wr(ra(1, 'h30), 32'h1234);
        rd(ra(1, 'h30));

        // R7: fault coincident with the clearing write
        cur_tag = "R7";
        step(1, ra(2, 'h20), 32'h0, 1, 2, 2, 64'h0077_0000_0010);
        rd(ra(2, 'h20)); rd(ra(2, 'h30)); rd(ra(2, 'h34));

        // R8: interrupt follows enable and status
        cur_tag = "R8";
        wr(ra(2, 0), 32'h1);
        rd(ra(2, 'h20));
        wr(ra(2, 0), 32'h4);
        rd(ra(2, 0));
        wr(ra(2, 'h20), 32'h0);
        rd(ra(2, 0));
        flt(5, 1, 64'h42, ra(5, 'h20));
        wr(ra(5, 0), 32'h4);
        rd(ra(5, 'h20));

        // Mixed traffic, tagged by register class
        cur_tag = "";
        for (int n = 0; n < 1500; n++) begin
            int c = int'($urandom % NCTX);
            int sel = int'($urandom % 11);
            int offs [10] = '{0, 8, 12, 16, 20, 32, 40, 48, 52, 4};
            bit [11:0] a = (sel == 10) ? 12'($urandom) : ra(c, offs[sel]);
            bit w = ($urandom % 3) == 0;
            bit [31:0] d = (($urandom % 2) == 0 && sel == 5) ? 32'h0 : $urandom;
            bit fv = ($urandom % 4) == 0;
            step(w, a, d, fv, int'($urandom % NCTX), int'($urandom % 4),
                 {$urandom, $urandom});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule